// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

The engine moves data between two memories under the control of two descriptor rings held in a shared descriptor memory. Software writes descriptors into the source ring and buffer descriptors into the destination ring. It then advances the write index of each ring. Each source descriptor names a source buffer by byte address, a byte count and a set of flags. The engine fetches it, claims a destination buffer from the destination ring and copies the data one 32-bit word at a time. It then advances its own read indices, which software can observe. A gather flag keeps the destination buffer open, so that the next source fragment continues at the following word of the same buffer.

A source descriptor is 64 bits wide. Bits 31:0 hold the buffer byte address, bits 47:32 hold the byte count and bits 63:48 hold the flags. A destination descriptor uses only bits 31:0, as the buffer address. Ring depth is a power of two, and both rings sit at configurable base entries of the descriptor memory. Faulty descriptors are skipped and set sticky error bits. A halt request stops the engine cleanly between descriptors and reports halt status.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset both read indices are 0, halt status is low, all error bits are 0 and no memory access, completion or target pulse is issued.
- R2: A valid source descriptor copies nbytes/4 words from word address addr[31:2] to consecutive words from the destination buffer's addr[31:2]. done_o pulses exactly one cycle after the last destination write.
- R3: A descriptor starts only when the source read index differs from the source write index and a destination buffer is available, meaning an open gathered buffer or a destination read index different from its write index. Otherwise nothing moves.
- R4: Both read indices advance by one per consumed entry and wrap modulo 2^RING_AW.
- R5: Flag bit 0 (gather) leaves the destination buffer open. The next descriptor's words follow on directly, and the destination read index advances only when a descriptor without bit 0 completes.
- R6: Each word has its four bytes reversed when flag bit 1 or src_swap_en_i is set, and reversed again when dst_swap_en_i is set. With both stages active the word passes unchanged.
- R7: Flag bit 2 suppresses done_o for that descriptor and flag bit 3 suppresses tgt_done_o. Otherwise both pulse together.
- R8: A byte count larger than max_len_i sets err_o[1]. The descriptor is consumed with no data moved, no pulse, and no destination entry taken.
- R9: A byte count of zero or one that is not a multiple of 4 sets err_o[0] and is skipped in the same way. This check takes priority over R8.
- R10: A destination buffer address with nonzero bits 1:0 sets err_o[2], consumes both the source and the destination entry and writes nothing.
- R11: A change of a write index that leaves that ring's occupancy (write minus read, modulo depth) below its previous value sets err_o[3] for the source ring or err_o[4] for the destination ring.
- R12: halt_req_i is sampled only between descriptors. halt_status_o rises one cycle after the done pulse of the descriptor in progress, or one cycle after the request when idle. While it is high no memory access occurs, and it falls after the request is withdrawn.
- R13: Error bits stay set until the matching err_clr_i bit is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_ring_base_i | input | DESC_AW | Descriptor memory entry of source ring slot 0 |
| dst_ring_base_i | input | DESC_AW | Descriptor memory entry of destination ring slot 0 |
| src_wr_idx_i | input | RING_AW | Source ring write index from software |
| dst_wr_idx_i | input | RING_AW | Destination ring write index from software |
| max_len_i | input | 16 | Largest accepted byte count per descriptor |
| src_swap_en_i | input | 1 | Source-side byte reversal enable |
| dst_swap_en_i | input | 1 | Destination-side byte reversal enable |
| halt_req_i | input | 1 | Halt request |
| err_clr_i | input | 5 | Per-bit clear of error status |
| src_rd_idx_o | output | RING_AW | Source ring read index |
| dst_rd_idx_o | output | RING_AW | Destination ring read index |
| halt_status_o | output | 1 | Engine is halted |
| err_o | output | 5 | Sticky errors: 0 length, 1 max length, 2 dest address, 3 source overflow, 4 dest overflow |
| desc_rd_en_o | output | 1 | Descriptor memory read strobe |
| desc_addr_o | output | DESC_AW | Descriptor memory entry address |
| desc_rdata_i | input | 64 | Descriptor read data, valid one cycle after the strobe |
| src_rd_en_o | output | 1 | Source data read strobe |
| src_addr_o | output | 30 | Source word address |
| src_rdata_i | input | 32 | Source read data, valid one cycle after the strobe |
| dst_wr_en_o | output | 1 | Destination write strobe |
| dst_addr_o | output | 30 | Destination word address |
| dst_wdata_o | output | 32 | Destination write data |
| done_o | output | 1 | Host completion pulse |
| tgt_done_o | output | 1 | Target completion pulse |

## Verification
Descriptor fetch costs one cycle, and a destination fetch costs one more. After that the copy overlaps each source read with the previous word's write, so the last write lands N+1 cycles after copying starts for N words. done_o follows the last write by exactly one cycle and halt status follows done_o by one more. The bench counts cycles at the falling edge and compares the logged cycle of each done pulse and halt rise against the logged cycle of the last write. For everything else it waits until the read index reaches the expected value, and then for a few more cycles, before it compares memory contents, indices and error bits.

// File: rtl/ce_pkg.sv
package ce_pkg;
  localparam int DESC_W  = 64;
  localparam int LEN_W   = 16;
  localparam int DWORD_W = 32;
  localparam int ERR_W   = 5;

  localparam int FLG_GATHER  = 0;
  localparam int FLG_SWAP    = 1;
  localparam int FLG_NO_HOST = 2;
  localparam int FLG_NO_TGT  = 3;

  localparam int ERR_LEN     = 0;
  localparam int ERR_MAXLEN  = 1;
  localparam int ERR_DADDR   = 2;
  localparam int ERR_SRC_OVF = 3;
  localparam int ERR_DST_OVF = 4;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] nbytes;
    logic [31:0] addr;
  } ce_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC_DESC,
    ST_DST_DESC,
    ST_COPY,
    ST_HALT
  } ce_state_e;
endpackage

// File: rtl/ce_ring_ptr.sv
module ce_ring_ptr #(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [AW-1:0] wr_idx_i,
  output logic [AW-1:0] rd_idx_o,
  output logic          pend_o,
  output logic          ovf_o
);
  logic [AW-1:0] rd_q, wr_prev_q, occ_now, occ_prev;

  // modulo-depth distances fall out of the AW-bit width
  assign occ_now  = wr_idx_i - rd_q;
  assign occ_prev = wr_prev_q - rd_q;
  assign pend_o   = (occ_now != '0);
  assign ovf_o    = (wr_idx_i != wr_prev_q) && (occ_now < occ_prev);
  assign rd_idx_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= '0;
      wr_prev_q <= '0;
    end else begin
      wr_prev_q <= wr_idx_i;
      if (adv_i) rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/ce_word_swap.sv
module ce_word_swap #(
  parameter int W = 32
) (
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  localparam int NB = W / 8;
  logic [W-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign rev[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
  end

  assign data_o = en_i ? rev : data_i;
endmodule

// File: rtl/ce_err_status.sv
module ce_err_status #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import ce_pkg::*;
#(
  parameter int RING_AW = 3,
  parameter int DESC_AW = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DESC_AW-1:0]  src_ring_base_i,
  input  logic [DESC_AW-1:0]  dst_ring_base_i,
  input  logic [RING_AW-1:0]  src_wr_idx_i,
  input  logic [RING_AW-1:0]  dst_wr_idx_i,
  input  logic [15:0]         max_len_i,
  input  logic                src_swap_en_i,
  input  logic                dst_swap_en_i,
  input  logic                halt_req_i,
  input  logic [4:0]          err_clr_i,
  output logic [RING_AW-1:0]  src_rd_idx_o,
  output logic [RING_AW-1:0]  dst_rd_idx_o,
  output logic                halt_status_o,
  output logic [4:0]          err_o,
  output logic                desc_rd_en_o,
  output logic [DESC_AW-1:0]  desc_addr_o,
  input  logic [63:0]         desc_rdata_i,
  output logic                src_rd_en_o,
  output logic [29:0]         src_addr_o,
  input  logic [31:0]         src_rdata_i,
  output logic                dst_wr_en_o,
  output logic [29:0]         dst_addr_o,
  output logic [31:0]         dst_wdata_o,
  output logic                done_o,
  output logic                tgt_done_o
);
  localparam int WA_W  = 30;
  localparam int CNT_W = LEN_W - 2;
  localparam int PADW  = DESC_AW - RING_AW;

  ce_state_e state_q, state_d;
  ce_desc_t  sd_in, dd_in, desc_q;
  logic [WA_W-1:0]  src_ptr_q, dst_ptr_q;
  logic [CNT_W-1:0] left_q;
  logic rd_vld_q, dst_open_q, done_q, tgt_q;
  logic src_adv, dst_adv, src_pend, dst_pend, src_ovf, dst_ovf;
  logic len_bad, too_long, finish;
  logic [ERR_W-1:0] err_set;
  logic [31:0] mid_word;
  logic unused_bits;

  assign sd_in = ce_desc_t'(desc_rdata_i);
  assign dd_in = ce_desc_t'(desc_rdata_i);
  assign unused_bits = ^{desc_q.addr[1:0], desc_q.flags[15:4], desc_q.nbytes,
                         dd_in.flags, dd_in.nbytes};

  ce_ring_ptr #(.AW(RING_AW)) u_src_ring (
    .clk_i, .rst_ni, .adv_i(src_adv), .wr_idx_i(src_wr_idx_i),
    .rd_idx_o(src_rd_idx_o), .pend_o(src_pend), .ovf_o(src_ovf)
  );

  ce_ring_ptr #(.AW(RING_AW)) u_dst_ring (
    .clk_i, .rst_ni, .adv_i(dst_adv), .wr_idx_i(dst_wr_idx_i),
    .rd_idx_o(dst_rd_idx_o), .pend_o(dst_pend), .ovf_o(dst_ovf)
  );

  ce_word_swap #(.W(DWORD_W)) u_swap_src (
    .en_i(desc_q.flags[FLG_SWAP] | src_swap_en_i),
    .data_i(src_rdata_i), .data_o(mid_word)
  );

  ce_word_swap #(.W(DWORD_W)) u_swap_dst (
    .en_i(dst_swap_en_i), .data_i(mid_word), .data_o(dst_wdata_o)
  );

  ce_err_status #(.W(ERR_W)) u_err (
    .clk_i, .rst_ni, .set_i(err_set), .clr_i(err_clr_i), .q_o(err_o)
  );

  assign len_bad  = (sd_in.nbytes == '0) || (sd_in.nbytes[1:0] != 2'b00);
  assign too_long = (sd_in.nbytes > max_len_i);
  assign finish   = (state_q == ST_COPY) && rd_vld_q && (left_q == '0);

  always_comb begin
    state_d      = state_q;
    desc_rd_en_o = 1'b0;
    desc_addr_o  = src_ring_base_i + {{PADW{1'b0}}, src_rd_idx_o};
    src_adv      = 1'b0;
    dst_adv      = 1'b0;
    err_set      = '0;
    err_set[ERR_SRC_OVF] = src_ovf;
    err_set[ERR_DST_OVF] = dst_ovf;
    unique case (state_q)
      ST_IDLE: begin
        if (halt_req_i) begin
          state_d = ST_HALT;
        end else if (src_pend && (dst_open_q || dst_pend)) begin
          desc_rd_en_o = 1'b1;
          state_d      = ST_SRC_DESC;
        end
      end
      ST_SRC_DESC: begin
        if (len_bad) begin
          err_set[ERR_LEN] = 1'b1;
          src_adv          = 1'b1;
          state_d          = ST_IDLE;
        end else if (too_long) begin
          err_set[ERR_MAXLEN] = 1'b1;
          src_adv             = 1'b1;
          state_d             = ST_IDLE;
        end else if (dst_open_q) begin
          state_d = ST_COPY;
        end else begin
          desc_rd_en_o = 1'b1;
          desc_addr_o  = dst_ring_base_i + {{PADW{1'b0}}, dst_rd_idx_o};
          state_d      = ST_DST_DESC;
        end
      end
      ST_DST_DESC: begin
        if (dd_in.addr[1:0] != 2'b00) begin
          err_set[ERR_DADDR] = 1'b1;
          src_adv            = 1'b1;
          dst_adv            = 1'b1;
          state_d            = ST_IDLE;
        end else begin
          state_d = ST_COPY;
        end
      end
      ST_COPY: begin
        if (finish) begin
          src_adv = 1'b1;
          dst_adv = !desc_q.flags[FLG_GATHER];
          state_d = ST_IDLE;
        end
      end
      ST_HALT: begin
        if (!halt_req_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign src_rd_en_o   = (state_q == ST_COPY) && (left_q != '0);
  assign src_addr_o    = src_ptr_q;
  assign dst_wr_en_o   = (state_q == ST_COPY) && rd_vld_q;
  assign dst_addr_o    = dst_ptr_q;
  assign halt_status_o = (state_q == ST_HALT);
  assign done_o        = done_q;
  assign tgt_done_o    = tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      desc_q     <= '0;
      src_ptr_q  <= '0;
      dst_ptr_q  <= '0;
      left_q     <= '0;
      rd_vld_q   <= 1'b0;
      dst_open_q <= 1'b0;
      done_q     <= 1'b0;
      tgt_q      <= 1'b0;
    end else begin
      state_q  <= state_d;
      rd_vld_q <= src_rd_en_o;
      done_q   <= finish && !desc_q.flags[FLG_NO_HOST];
      tgt_q    <= finish && !desc_q.flags[FLG_NO_TGT];
      if (state_q == ST_SRC_DESC) begin
        desc_q    <= sd_in;
        src_ptr_q <= sd_in.addr[31:2];
        left_q    <= sd_in.nbytes[LEN_W-1:2];
      end else if (src_rd_en_o) begin
        src_ptr_q <= src_ptr_q + 1'b1;
        left_q    <= left_q - 1'b1;
      end
      if (state_q == ST_DST_DESC && dd_in.addr[1:0] == 2'b00) begin
        dst_ptr_q  <= dd_in.addr[31:2];
        dst_open_q <= 1'b1;
      end else if (dst_wr_en_o) begin
        dst_ptr_q <= dst_ptr_q + 1'b1;
      end
      if (finish && !desc_q.flags[FLG_GATHER]) dst_open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_copy_engine_chk.sv
module ring_copy_engine_chk #(
  parameter int RING_AW = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               halt_req_i,
  input logic [4:0]         err_clr_i,
  input logic [RING_AW-1:0] src_rd_idx_o,
  input logic [RING_AW-1:0] dst_rd_idx_o,
  input logic               halt_status_o,
  input logic [4:0]         err_o,
  input logic               desc_rd_en_o,
  input logic               src_rd_en_o,
  input logic               dst_wr_en_o,
  input logic               done_o
);
  // R2
  done_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(dst_wr_en_o));

  // R2
  write_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_wr_en_o |-> $past(src_rd_en_o));

  // R4
  src_idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_rd_idx_o) |-> src_rd_idx_o == RING_AW'($past(src_rd_idx_o) + 1'b1));

  // R4
  dst_idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dst_rd_idx_o) |-> dst_rd_idx_o == RING_AW'($past(dst_rd_idx_o) + 1'b1));

  // R12
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_status_o |-> !(src_rd_en_o || dst_wr_en_o || desc_rd_en_o));

  // R12
  halt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_status_o) |-> $past(halt_req_i));

  // R13
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> (($past(err_o) & ~err_o & ~$past(err_clr_i)) == 5'd0));
endmodule

bind ring_copy_engine ring_copy_engine_chk #(.RING_AW(RING_AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_req_i(halt_req_i), .err_clr_i(err_clr_i),
  .src_rd_idx_o(src_rd_idx_o), .dst_rd_idx_o(dst_rd_idx_o),
  .halt_status_o(halt_status_o), .err_o(err_o), .desc_rd_en_o(desc_rd_en_o),
  .src_rd_en_o(src_rd_en_o), .dst_wr_en_o(dst_wr_en_o), .done_o(done_o)
);

// File: tb/ring_copy_engine_tb_top.sv
`timescale 1ns/1ps
module ring_copy_engine_tb_top;
  localparam int RING_AW = 3;
  localparam int DESC_AW = 6;
  localparam int DEPTH   = 1 << RING_AW;
  localparam int SB      = 0;
  localparam int DB      = 16;
  localparam int WD_LIM  = 100000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [DESC_AW-1:0] src_ring_base_i = DESC_AW'(SB), dst_ring_base_i = DESC_AW'(DB);
  logic [RING_AW-1:0] src_wr_idx_i = '0, dst_wr_idx_i = '0;
  logic [15:0] max_len_i = 16'd64;
  logic src_swap_en_i = 1'b0, dst_swap_en_i = 1'b0, halt_req_i = 1'b0;
  logic [4:0] err_clr_i = '0;
  logic [RING_AW-1:0] src_rd_idx_o, dst_rd_idx_o;
  logic halt_status_o, desc_rd_en_o, src_rd_en_o, dst_wr_en_o, done_o, tgt_done_o;
  logic [4:0] err_o;
  logic [DESC_AW-1:0] desc_addr_o;
  logic [63:0] desc_rdata_i = '0;
  logic [29:0] src_addr_o, dst_addr_o;
  logic [31:0] src_rdata_i = '0, dst_wdata_o;

  ring_copy_engine #(.RING_AW(RING_AW), .DESC_AW(DESC_AW)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  logic [63:0] desc_mem [64];
  logic [31:0] src_mem  [256];
  logic [31:0] dst_mem  [256];

  always @(posedge clk_i) begin
    if (desc_rd_en_o) desc_rdata_i <= desc_mem[desc_addr_o];
    if (src_rd_en_o)  src_rdata_i  <= src_mem[src_addr_o[7:0]];
    if (dst_wr_en_o)  dst_mem[dst_addr_o[7:0]] <= dst_wdata_o;
  end

  int cyc = 0, wr_cnt = 0, done_cnt = 0, tgt_cnt = 0;
  int last_wr_cyc = 0, last_done_cyc = 0, halt_rise_cyc = 0;
  logic halt_prev = 1'b0;
  int checks = 0, fails = 0;

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (dst_wr_en_o) begin wr_cnt <= wr_cnt + 1; last_wr_cyc <= cyc; end
    if (done_o) begin done_cnt <= done_cnt + 1; last_done_cyc <= cyc; end
    if (tgt_done_o) tgt_cnt <= tgt_cnt + 1;
    if (halt_status_o && !halt_prev) halt_rise_cyc <= cyc;
    halt_prev <= halt_status_o;
    if (cyc > WD_LIM) begin
      $display("FAIL watchdog: run hung act=%0d exp<=%0d", cyc, WD_LIM);
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
    end
  end

  function automatic logic [31:0] pat(input int i);
    return {8'(i), 8'(i + 64), 8'(i + 128), 8'(i + 192)};
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  int s_wr = 0, d_wr = 0;

  task automatic add_src(input logic [31:0] a, input logic [15:0] n, input logic [15:0] f);
    desc_mem[SB + s_wr] = {f, n, a};
    s_wr = (s_wr + 1) % DEPTH;
    src_wr_idx_i = RING_AW'(s_wr);
  endtask

  task automatic add_dst(input logic [31:0] a);
    desc_mem[DB + d_wr] = {32'h0, a};
    d_wr = (d_wr + 1) % DEPTH;
    dst_wr_idx_i = RING_AW'(d_wr);
  endtask

  task automatic drain();
    for (int t = 0; t < 300 && int'(src_rd_idx_o) != s_wr; t++) tick(1);
    tick(3);
  endtask

  task automatic t_reset();
    chk(src_rd_idx_o == 0 && dst_rd_idx_o == 0, "R1 indices", {src_rd_idx_o, dst_rd_idx_o}, 0);
    chk(halt_status_o == 0 && err_o == 0, "R1 halt/err", {halt_status_o, err_o}, 0);
    chk(!desc_rd_en_o && !src_rd_en_o && !dst_wr_en_o && !done_o && !tgt_done_o,
        "R1 strobes", {desc_rd_en_o, src_rd_en_o, dst_wr_en_o, done_o, tgt_done_o}, 0);
  endtask

  task automatic t_basic();
    add_src(32'h100, 16'd16, 16'h0);
    tick(20);
    chk(src_rd_idx_o == 0 && wr_cnt == 0, "R3 no dest entry", {src_rd_idx_o, 8'(wr_cnt)}, 0);
    add_dst(32'h200);
    drain();
    for (int i = 0; i < 4; i++)
      chk(dst_mem[8'h80 + i] == pat(8'h40 + i), "R2 copy data", dst_mem[8'h80 + i], pat(8'h40 + i));
    chk(wr_cnt == 4, "R2 write count", wr_cnt, 4);
    chk(last_done_cyc == last_wr_cyc + 1, "R2 done timing", last_done_cyc, last_wr_cyc + 1);
    chk(dst_rd_idx_o == 1, "R4 dst index", dst_rd_idx_o, 1);
  endtask

  task automatic t_swap();
    add_dst(32'h240); add_src(32'h100, 16'd8, 16'h2); drain();
    chk(dst_mem[8'h90] == rev(pat(8'h40)) && dst_mem[8'h91] == rev(pat(8'h41)),
        "R6 flag swap", dst_mem[8'h90], rev(pat(8'h40)));
    src_swap_en_i = 1'b1;
    add_dst(32'h260); add_src(32'h100, 16'd8, 16'h0); drain();
    chk(dst_mem[8'h98] == rev(pat(8'h40)), "R6 source ring swap", dst_mem[8'h98], rev(pat(8'h40)));
    src_swap_en_i = 1'b0; dst_swap_en_i = 1'b1;
    add_dst(32'h280); add_src(32'h100, 16'd8, 16'h2); drain();
    chk(dst_mem[8'hA1] == pat(8'h41), "R6 double swap", dst_mem[8'hA1], pat(8'h41));
    dst_swap_en_i = 1'b0;
  endtask

  task automatic t_gather();
    int d0, s1;
    d0 = d_wr;
    s1 = (s_wr + 1) % DEPTH;
    add_dst(32'h300);
    add_src(32'h100, 16'd8, 16'h1);
    add_src(32'h180, 16'd4, 16'h0);
    for (int t = 0; t < 300 && int'(src_rd_idx_o) != s1; t++) tick(1);
    chk(int'(dst_rd_idx_o) == d0, "R5 dest held open", dst_rd_idx_o, d0);
    drain();
    chk(dst_mem[8'hC0] == pat(8'h40) && dst_mem[8'hC1] == pat(8'h41), "R5 first fragment",
        dst_mem[8'hC1], pat(8'h41));
    chk(dst_mem[8'hC2] == pat(8'h60), "R5 second fragment", dst_mem[8'hC2], pat(8'h60));
    chk(int'(dst_rd_idx_o) == d_wr, "R5 dest released", dst_rd_idx_o, d_wr);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 3; k++) begin
      add_dst(32'h340 + 32'(4 * k));
      add_src(32'h104 + 32'(4 * k), 16'd4, 16'h0);
    end
    drain();
    chk(src_rd_idx_o == 1 && dst_rd_idx_o == 0, "R4 wrap", {src_rd_idx_o, dst_rd_idx_o}, {3'd1, 3'd0});
    chk(dst_mem[8'hD2] == pat(8'h43), "R4 data after wrap", dst_mem[8'hD2], pat(8'h43));
  endtask

  task automatic t_irq();
    int dc, tc;
    dc = done_cnt; tc = tgt_cnt;
    add_dst(32'h350); add_src(32'h100, 16'd4, 16'h4); drain();
    chk(done_cnt == dc && tgt_cnt == tc + 1, "R7 host pulse off", {done_cnt, tgt_cnt}, {dc, tc + 1});
    add_dst(32'h354); add_src(32'h100, 16'd4, 16'h8); drain();
    chk(done_cnt == dc + 1 && tgt_cnt == tc + 1, "R7 target pulse off", {done_cnt, tgt_cnt}, {dc + 1, tc + 1});
  endtask

  task automatic clear_err();
    err_clr_i = 5'h1F; tick(1); err_clr_i = 5'h0; tick(1);
  endtask

  task automatic t_errors();
    int wc, d0;
    add_dst(32'h302);
    d0 = int'(dst_rd_idx_o);
    wc = wr_cnt;
    add_src(32'h100, 16'd68, 16'h0); drain();
    chk(err_o == 5'b00010, "R8 max length", err_o, 5'b00010);
    chk(wr_cnt == wc && int'(dst_rd_idx_o) == d0, "R8 skipped", {wr_cnt, 32'(dst_rd_idx_o)}, {wc, d0});
    tick(5);
    chk(err_o == 5'b00010, "R13 sticky", err_o, 5'b00010);
    clear_err();
    chk(err_o == 5'b0, "R13 cleared", err_o, 0);
    add_src(32'h100, 16'd6, 16'h0); drain();
    chk(err_o == 5'b00001, "R9 odd length", err_o, 5'b00001);
    clear_err();
    add_src(32'h100, 16'd0, 16'h0); drain();
    chk(err_o == 5'b00001 && wr_cnt == wc, "R9 zero length", err_o, 5'b00001);
    clear_err();
    add_src(32'h100, 16'd66, 16'h0); drain();
    chk(err_o == 5'b00001, "R9 priority over R8", err_o, 5'b00001);
    clear_err();
    add_src(32'h100, 16'd4, 16'h0); drain();
    chk(err_o == 5'b00100, "R10 dest address", err_o, 5'b00100);
    chk(wr_cnt == wc && int'(dst_rd_idx_o) == d_wr, "R10 both consumed", {wr_cnt, 32'(dst_rd_idx_o)}, {wc, d_wr});
    clear_err();
  endtask

  task automatic t_halt_ovf();
    int wc;
    add_dst(32'h3A0); add_src(32'h100, 16'd16, 16'h0);
    for (int t = 0; t < 300 && !dst_wr_en_o; t++) tick(1);
    halt_req_i = 1'b1;
    tick(1);
    chk(halt_status_o == 0, "R12 no halt mid-descriptor", halt_status_o, 0);
    drain();
    chk(halt_status_o == 1, "R12 halted", halt_status_o, 1);
    chk(halt_rise_cyc == last_done_cyc + 1, "R12 halt timing", halt_rise_cyc, last_done_cyc + 1);
    chk(dst_mem[8'hEB] == pat(8'h43), "R12 descriptor finished", dst_mem[8'hEB], pat(8'h43));
    wc = wr_cnt;
    add_dst(32'h3C0); add_src(32'h100, 16'd4, 16'h0);
    tick(20);
    chk(int'(src_rd_idx_o) == (s_wr + DEPTH - 1) % DEPTH && wr_cnt == wc, "R12 frozen",
        src_rd_idx_o, (s_wr + DEPTH - 1) % DEPTH);
    src_wr_idx_i = RING_AW'(s_wr + 1); tick(2);
    src_wr_idx_i = RING_AW'(s_wr + DEPTH - 1); tick(2);
    src_wr_idx_i = RING_AW'(s_wr); tick(2);
    chk(err_o == 5'b01000, "R11 source overflow", err_o, 5'b01000);
    dst_wr_idx_i = RING_AW'(d_wr + 1); tick(2);
    dst_wr_idx_i = RING_AW'(d_wr + DEPTH - 1); tick(2);
    dst_wr_idx_i = RING_AW'(d_wr); tick(2);
    chk(err_o == 5'b11000, "R11 dest overflow", err_o, 5'b11000);
    clear_err();
    halt_req_i = 1'b0;
    drain();
    chk(halt_status_o == 0, "R12 released", halt_status_o, 0);
    chk(dst_mem[8'hF0] == pat(8'h40) && wr_cnt == wc + 1, "R12 resumed", dst_mem[8'hF0], pat(8'h40));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) src_mem[i] = pat(i);
    for (int i = 0; i < 64; i++) desc_mem[i] = '0;
    tick(3);
    t_reset();
    rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_basic();
    t_swap();
    t_gather();
    t_wrap();
    t_irq();
    t_errors();
    t_halt_ovf();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule